// File: doc/BRIEF.md
# Partitioned compare, min/max and leading-bit search unit

This execution unit works on a 64-bit datapath split into equal lanes of 8, 16, 32 or 64 bits. For each lane it can make a greater-than or less-or-equal decision between operands A and B. It can also return the smaller and the larger of the two values at once on two separate result ports, which sorts the pair in one operation. A fourth function searches A for its most significant set bit, or for its most significant clear bit, and returns both a one-hot mask and the bit's index. A signedness input chooses two's-complement or unsigned ordering for compare and min/max.

Every operation takes exactly two clock edges from `valid_i` to `valid_o`. The unit takes a new operation on every cycle. The first stage forms per-byte partial results: the byte order with the lane's sign bit adjusted, byte equality, and the leading bit position within each byte. The second stage merges these partial results across each lane and registers the outputs.

Top module: `simd_cmp_unit`

## Requirements
- R1: While reset is held, and until the first operation completes after reset, `valid_o` is 0 and both result ports are 0.
- R2: A result appears with `valid_o`=1 exactly two rising clock edges after `valid_i` was sampled high. A cycle where `valid_i` is low gives `valid_o`=0 two edges later.
- R3: Opcode 0 (greater-than) sets every bit of a lane in `res0_o` to 1 when A > B in that lane and to 0 otherwise. `res1_o` is 0.
- R4: Opcode 1 (less-or-equal) sets a lane of `res0_o` to all ones when A <= B and to all zeros otherwise. `res1_o` is 0.
- R5: Opcode 2 (min/max) places the lane minimum of A and B on `res0_o` and the lane maximum on `res1_o`.
- R6: When A equals B in a lane under opcode 2, both result ports carry that common value in that lane.
- R7: With `signed_i`=1, opcodes 0 to 2 order lanes as two's-complement numbers. With `signed_i`=0 they order lanes as unsigned numbers.
- R8: `size_i` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Each lane's result depends only on that lane's operand bits.
- R9: Opcode 3 puts on `res0_o` a one-hot mask of the highest set bit of A in each lane. It puts that bit's index, zero-extended in the lane, on `res1_o`. B has no effect.
- R10: Opcode 4 does the same as opcode 3, but for the highest clear bit of A.
- R11: Under opcode 3 or 4, a lane with no bit of the searched polarity gives a zero mask and an all-ones lane on `res1_o`.
- R12: Operations issued on consecutive cycles each return their own correct result on consecutive cycles, in issue order.
- R13: Opcodes 5, 6 and 7 return zero on both result ports, still with `valid_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode (0 gt, 1 le, 2 min/max, 3 msb set, 4 msb clear) |
| size_i | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64 bits) |
| signed_i | input | 1 | Two's-complement ordering for opcodes 0 to 2 |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| valid_o | output | 1 | Result strobe |
| res0_o | output | 64 | Compare mask, minimum, or bit mask |
| res1_o | output | 64 | Zero, maximum, or bit index |

## Verification
Several properties are checked on every cycle:
- The two-edge valid latency.
- Compare lanes are all zeros or all ones, with a zero second port.
- For full-width lanes, the minimum never exceeds the maximum, in both orderings.
- The full-width bit mask is one-hot or zero, and a zero mask comes with an all-ones index.
- Undefined opcodes give zero outputs.

Only the bench's directed scenarios can show that the values themselves are right against an independent model. That covers which lane wins a compare, the exact index found, that B is ignored by the search, that equal operands land on both ports, and that back-to-back operations keep their order and results.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;
  localparam int BYTE_W = 8;
  localparam int SZ_W   = 2;
  localparam int NSZ    = 4;

  localparam logic [2:0] OP_GT     = 3'd0;
  localparam logic [2:0] OP_LE     = 3'd1;
  localparam logic [2:0] OP_MINMAX = 3'd2;
  localparam logic [2:0] OP_MSB1   = 3'd3;
  localparam logic [2:0] OP_MSB0   = 3'd4;
endpackage

// File: rtl/scu_byte_stage.sv
module scu_byte_stage
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [2:0]             op_i,
  input  logic [SZ_W-1:0]        size_i,
  input  logic                   signed_i,
  input  logic [DATA_W-1:0]      a_i,
  input  logic [DATA_W-1:0]      b_i,
  output logic                   valid_o,
  output logic [2:0]             op_o,
  output logic [SZ_W-1:0]        size_o,
  output logic                   signed_o,
  output logic [DATA_W-1:0]      a_o,
  output logic [DATA_W-1:0]      b_o,
  output logic [NB-1:0]          gt_o,
  output logic [NB-1:0]          eq_o,
  output logic [NB-1:0]          has_o,
  output logic [NB-1:0][2:0]     pos_o
);
  logic [NB-1:0]      gt_d, eq_d, has_d;
  logic [NB-1:0][2:0] pos_d;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam int GP1 = g + 1;
    logic [BYTE_W-1:0] ab, bb, ax, bx, sv;
    logic              top, flip;
    logic [2:0]        p;

    assign ab   = a_i[g*BYTE_W +: BYTE_W];
    assign bb   = b_i[g*BYTE_W +: BYTE_W];
    // top byte of its lane carries the sign bit
    assign top  = ((GP1 & ((1 << size_i) - 1)) == 0);
    assign flip = signed_i & top;
    assign ax   = {ab[BYTE_W-1] ^ flip, ab[BYTE_W-2:0]};
    assign bx   = {bb[BYTE_W-1] ^ flip, bb[BYTE_W-2:0]};
    assign sv   = (op_i == OP_MSB0) ? ~ab : ab;

    always_comb begin
      p = '0;
      for (int i = 0; i < BYTE_W; i++) begin
        if (sv[i]) p = 3'(i);
      end
    end

    assign gt_d[g]  = ax > bx;
    assign eq_d[g]  = ab == bb;
    assign has_d[g] = |sv;
    assign pos_d[g] = p;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      op_o     <= '0;
      size_o   <= '0;
      signed_o <= 1'b0;
      a_o      <= '0;
      b_o      <= '0;
      gt_o     <= '0;
      eq_o     <= '0;
      has_o    <= '0;
      pos_o    <= '0;
    end else begin
      valid_o  <= valid_i;
      op_o     <= op_i;
      size_o   <= size_i;
      signed_o <= signed_i;
      a_o      <= a_i;
      b_o      <= b_i;
      gt_o     <= gt_d;
      eq_o     <= eq_d;
      has_o    <= has_d;
      pos_o    <= pos_d;
    end
  end
endmodule

// File: rtl/scu_lane_merge.sv
module scu_lane_merge
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic [2:0]         op_i,
  input  logic [SZ_W-1:0]    size_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [NB-1:0]      gt_i,
  input  logic [NB-1:0]      eq_i,
  input  logic [NB-1:0]      has_i,
  input  logic [NB-1:0][2:0] pos_i,
  output logic [DATA_W-1:0]  res0_o,
  output logic [DATA_W-1:0]  res1_o
);
  logic [NSZ-1:0][DATA_W-1:0] r0_all, r1_all;

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int LB = 1 << s;
    localparam int LW = BYTE_W * LB;
    localparam int NL = NB / LB;
    logic [DATA_W-1:0] r0_s, r1_s;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic          lgt, leq, fnd;
      logic [5:0]    idx;
      logic [LW-1:0] la, lb, lr0, lr1;

      assign la = a_i[l*LW +: LW];
      assign lb = b_i[l*LW +: LW];

      // top-down scan: first unequal byte decides order, first populated byte holds the leading bit
      always_comb begin
        lgt = 1'b0;
        leq = 1'b1;
        fnd = 1'b0;
        idx = '0;
        for (int j = LB - 1; j >= 0; j--) begin
          if (leq && !eq_i[l*LB+j]) begin
            lgt = gt_i[l*LB+j];
            leq = 1'b0;
          end
          if (!fnd && has_i[l*LB+j]) begin
            fnd = 1'b1;
            idx = 6'(j * BYTE_W) + 6'(pos_i[l*LB+j]);
          end
        end
      end

      always_comb begin
        lr0 = '0;
        lr1 = '0;
        case (op_i)
          OP_GT:     lr0 = lgt ? '1 : '0;
          OP_LE:     lr0 = lgt ? '0 : '1;
          OP_MINMAX: begin
            lr0 = lgt ? lb : la;
            lr1 = lgt ? la : lb;
          end
          OP_MSB1, OP_MSB0: begin
            lr0 = fnd ? (LW'(1) << idx) : '0;
            lr1 = fnd ? LW'(idx) : '1;
          end
          default: begin
            lr0 = '0;
            lr1 = '0;
          end
        endcase
      end

      assign r0_s[l*LW +: LW] = lr0;
      assign r1_s[l*LW +: LW] = lr1;
    end

    assign r0_all[s] = r0_s;
    assign r1_all[s] = r1_s;
  end

  assign res0_o = r0_all[size_i];
  assign res1_o = r1_all[size_i];
endmodule

// File: rtl/simd_cmp_unit.sv
module simd_cmp_unit
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res0_o,
  output logic [DATA_W-1:0] res1_o
);
  logic              s1_valid, s1_sgn;
  logic [2:0]        s1_op;
  logic [SZ_W-1:0]   s1_size;
  logic [DATA_W-1:0] s1_a, s1_b, m_r0, m_r1;
  logic [NB-1:0]     s1_gt, s1_eq, s1_has;
  logic [NB-1:0][2:0] s1_pos;
  logic [2:0]        s2_op;
  logic [SZ_W-1:0]   s2_size;
  logic              s2_sgn;

  scu_byte_stage #(.DATA_W(DATA_W)) i_byte_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .signed_i (signed_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .valid_o  (s1_valid),
    .op_o     (s1_op),
    .size_o   (s1_size),
    .signed_o (s1_sgn),
    .a_o      (s1_a),
    .b_o      (s1_b),
    .gt_o     (s1_gt),
    .eq_o     (s1_eq),
    .has_o    (s1_has),
    .pos_o    (s1_pos)
  );

  scu_lane_merge #(.DATA_W(DATA_W)) i_lane_merge (
    .op_i   (s1_op),
    .size_i (s1_size),
    .a_i    (s1_a),
    .b_i    (s1_b),
    .gt_i   (s1_gt),
    .eq_i   (s1_eq),
    .has_i  (s1_has),
    .pos_i  (s1_pos),
    .res0_o (m_r0),
    .res1_o (m_r1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res0_o  <= '0;
      res1_o  <= '0;
      s2_op   <= '0;
      s2_size <= '0;
      s2_sgn  <= 1'b0;
    end else begin
      valid_o <= s1_valid;
      res0_o  <= s1_valid ? m_r0 : '0;
      res1_o  <= s1_valid ? m_r1 : '0;
      s2_op   <= s1_op;
      s2_size <= s1_size;
      s2_sgn  <= s1_sgn;
    end
  end

  // R2: fixed two-edge latency
  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);
  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);

  // R3 / R4: compare lanes are saturated masks, second port idle
  for (genvar k = 0; k < NB; k++) begin : g_chk_byte
    assert_cmp_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && (s2_op == OP_GT || s2_op == OP_LE)) |->
        (res0_o[k*BYTE_W +: BYTE_W] == '0 || res0_o[k*BYTE_W +: BYTE_W] == '1));
  end
  assert_cmp_res1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (s2_op == OP_GT || s2_op == OP_LE)) |-> res1_o == '0);

  // R5 / R7: full-width lane ordering of min and max
  assert_minmax_u_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && s2_op == OP_MINMAX && s2_size == 2'd3 && !s2_sgn) |->
      res0_o[63:0] <= res1_o[63:0]);
  assert_minmax_s_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && s2_op == OP_MINMAX && s2_size == 2'd3 && s2_sgn) |->
      $signed(res0_o[63:0]) <= $signed(res1_o[63:0]));

  // R9 / R11: full-width bit search
  assert_msb_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (s2_op == OP_MSB1 || s2_op == OP_MSB0) && s2_size == 2'd3) |->
      $onehot0(res0_o[63:0]));
  assert_msb_none_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (s2_op == OP_MSB1 || s2_op == OP_MSB0) && s2_size == 2'd3 &&
     res0_o[63:0] == '0) |-> res1_o[63:0] == '1);

  // R13: undefined opcodes
  assert_undef_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && s2_op > OP_MSB0) |-> (res0_o == '0 && res1_o == '0));

  // R1: idle outputs carry no data
  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (res0_o == '0 && res1_o == '0));
endmodule

// File: tb/test_simd_cmp_unit.sv
`timescale 1ns/1ps
module test_simd_cmp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [2:0]  op_i;
  logic [1:0]  size_i;
  logic        signed_i;
  logic [63:0] a_i, b_i;
  logic        valid_o;
  logic [63:0] res0_o, res1_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  simd_cmp_unit i_simd_cmp_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .size_i(size_i), .signed_i(signed_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .res0_o(res0_o), .res1_o(res1_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // independent reference, written from the requirements
  function automatic void model(input logic [2:0] op, input logic [1:0] sz, input logic sg,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r0, output logic [63:0] r1);
    int lw = 8 << sz;
    logic [63:0] m = (lw == 64) ? '1 : ((64'd1 << lw) - 1);
    r0 = '0;
    r1 = '0;
    for (int l = 0; l < 64 / lw; l++) begin
      logic [63:0] la, lb, sa, sb, o0, o1, v;
      logic gt, fnd;
      int idx;
      la = (a >> (l * lw)) & m;
      lb = (b >> (l * lw)) & m;
      sa = (sg && la[lw-1]) ? (la | ~m) : la;
      sb = (sg && lb[lw-1]) ? (lb | ~m) : lb;
      gt = sg ? ($signed(sa) > $signed(sb)) : (la > lb);
      o0 = '0;
      o1 = '0;
      case (op)
        3'd0: o0 = gt ? m : '0;
        3'd1: o0 = gt ? '0 : m;
        3'd2: begin o0 = gt ? lb : la; o1 = gt ? la : lb; end
        3'd3, 3'd4: begin
          v = (op == 3'd4) ? (~la & m) : la;
          fnd = 1'b0;
          idx = 0;
          for (int i = 0; i < lw; i++) if (v[i]) begin fnd = 1'b1; idx = i; end
          o0 = fnd ? (64'd1 << idx) : '0;
          o1 = fnd ? 64'(idx) : m;
        end
        default: ;
      endcase
      r0 |= (o0 & m) << (l * lw);
      r1 |= (o1 & m) << (l * lw);
    end
  endfunction

  task automatic drive(input logic [2:0] op, input logic [1:0] sz, input logic sg,
                       input logic [63:0] a, input logic [63:0] b);
    valid_i = 1'b1; op_i = op; size_i = sz; signed_i = sg; a_i = a; b_i = b;
  endtask

  // issue one op, sample two edges later, then confirm the strobe drops
  task automatic run_op(input string req, input logic [2:0] op, input logic [1:0] sz,
                        input logic sg, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] e0, e1;
    model(op, sz, sg, a, b, e0, e1);
    @(negedge clk_i);
    drive(op, sz, sg, a, b);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " R2 not early"}, 64'(valid_o), 64'd0);
    @(negedge clk_i);
    chk({req, " R2 valid"}, 64'(valid_o), 64'd1);
    chk({req, " res0"}, res0_o, e0);
    chk({req, " res1"}, res1_o, e1);
  endtask

  task automatic t_reset;
    chk("R1 valid", 64'(valid_o), 64'd0);
    chk("R1 res0", res0_o, 64'd0);
    chk("R1 res1", res1_o, 64'd0);
  endtask

  task automatic t_compare;
    logic [63:0] a = 64'h0180_ff00_7f01_0203;
    logic [63:0] b = 64'h0081_00ff_7f02_0103;
    for (int s = 0; s < 4; s++) begin
      run_op("R3 R8 gt", 3'd0, 2'(s), 1'b0, a, b);
      run_op("R4 R8 le", 3'd1, 2'(s), 1'b0, a, b);
    end
    run_op("R3 gt equal", 3'd0, 2'd3, 1'b0, a, a);
    run_op("R4 le equal", 3'd1, 2'd3, 1'b0, a, a);
  endtask

  task automatic t_minmax;
    logic [63:0] a = 64'h8000_7fff_0012_ff34;
    logic [63:0] b = 64'h7fff_8000_0034_0012;
    for (int s = 0; s < 4; s++) begin
      run_op("R5 R8 minmax u", 3'd2, 2'(s), 1'b0, a, b);
      run_op("R5 R7 minmax s", 3'd2, 2'(s), 1'b1, a, b);
    end
    run_op("R6 equal", 3'd2, 2'd1, 1'b1, a, a);
    run_op("R6 equal partial", 3'd2, 2'd0, 1'b0, a, {a[63:32], b[31:0]});
  endtask

  task automatic t_signed;
    // 0x80 vs 0x7f: unsigned greater, signed smaller
    run_op("R7 gt u8", 3'd0, 2'd0, 1'b0, 64'h80, 64'h7f);
    run_op("R7 gt s8", 3'd0, 2'd0, 1'b1, 64'h80, 64'h7f);
    run_op("R7 le s64", 3'd1, 2'd3, 1'b1, 64'hffff_ffff_ffff_ffff, 64'd1);
    run_op("R7 le u64", 3'd1, 2'd3, 1'b0, 64'hffff_ffff_ffff_ffff, 64'd1);
    run_op("R7 gt s16 mid", 3'd0, 2'd1, 1'b1, 64'h0080_ff00, 64'h0070_0100);
  endtask

  task automatic t_msb;
    logic [63:0] a = 64'h0000_0100_8001_f00f;
    for (int s = 0; s < 4; s++) begin
      run_op("R9 R8 msb1", 3'd3, 2'(s), 1'b0, a, 64'd0);
      run_op("R9 msb1 b ignored", 3'd3, 2'(s), 1'b1, a, '1);
      run_op("R10 msb0", 3'd4, 2'(s), 1'b0, a, 64'h5555);
    end
    run_op("R11 none set", 3'd3, 2'd3, 1'b0, 64'd0, 64'd7);
    run_op("R11 none clear", 3'd4, 2'd2, 1'b0, '1, 64'd0);
    run_op("R11 mixed lanes", 3'd3, 2'd0, 1'b0, 64'h00ff_0001_0080_0000, 64'd0);
    run_op("R9 top bit", 3'd3, 2'd3, 1'b0, 64'h8000_0000_0000_0001, 64'd0);
  endtask

  task automatic t_undef;
    for (int o = 5; o < 8; o++)
      run_op("R13 undef", 3'(o), 2'd0, 1'b1, 64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321);
  endtask

  task automatic t_stream;
    logic [2:0]  sop[6] = '{3'd0, 3'd2, 3'd3, 3'd1, 3'd4, 3'd2};
    logic [1:0]  ssz[6] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd3};
    logic [63:0] sa[6]  = '{64'h11, 64'hf0f0_0f0f, 64'h10, 64'h5, 64'hfe, 64'h9000_0000_0000_0000};
    logic [63:0] sb[6]  = '{64'h10, 64'h0f0f_f0f0, 64'h0, 64'h6, 64'h1, 64'h1000_0000_0000_0000};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        logic [63:0] e0, e1;
        model(sop[i-2], ssz[i-2], 1'b1, sa[i-2], sb[i-2], e0, e1);
        chk("R12 stream valid", 64'(valid_o), 64'd1);
        chk("R12 stream res0", res0_o, e0);
        chk("R12 stream res1", res1_o, e1);
      end
      if (i < 6) drive(sop[i], ssz[i], 1'b1, sa[i], sb[i]);
      else valid_i = 1'b0;
    end
    @(negedge clk_i);
    chk("R2 drained", 64'(valid_o), 64'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; size_i = '0; signed_i = 1'b0;
    a_i = '0; b_i = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_compare();
    t_minmax();
    t_signed();
    t_msb();
    t_undef();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule